// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block derives the serial clock for an I2C controller from the module clock. One 8-bit divider register holds three fields: a multiplier select, a prescaler select and a tap select. The first two fields set how many module clocks make up one internal tick. The tap field sets how many ticks make up each SCL half-period. It also sets how many ticks after each SCL falling edge the controller may change SDA.

When enabled, the block drives a free-running, symmetric SCL waveform. It also pulses a one-cycle strobe in each low phase, which marks the moment for the shift engine to move SDA. A new divider value is loaded into the active settings only when SCL falls, or while the block is disabled. As a result, no half-period is ever cut short.

Top module: `i2c_bitclk_gen`

## Requirements
- R1: The divider register resets to 0x00. It can be written in any cycle through `div_we`/`div_wdata`, and `div_rdata` returns the written value one cycle later.
- R2: The tap select field (bits 2:0), codes 0 to 7, gives SCL tap counts of 5, 6, 7, 8, 9, 10, 12 and 15 ticks. SCL stays high for that many ticks and low for that many ticks.
- R3: The tick length is M*P module clocks. The multiplier field (bits 7:6) gives M = 1, 2, 4, 1 for codes 0 to 3. The prescaler field (bits 5:3), code c, gives P = 2*(c+1).
- R4: In each SCL low phase, `sda_stb_o` rises exactly once, for one cycle, S*M*P cycles after the falling edge. S is 1, 1, 2, 2, 3, 3, 4, 4 for tap codes 0 to 7. SCL is low whenever the strobe is high.
- R5: While enabled, the active settings change only at an SCL falling edge. A write takes effect at the first falling edge after the edge that captures it. A write captured at the same edge as a fall therefore applies from the following fall.
- R6: While `enable` is low, SCL is high and `sda_stb_o` is low from the next cycle on. The counters are cleared and the active settings follow the register.
- R7: After `enable` rises, SCL first falls at the (T*M*P)-th clock edge at which `enable` is sampled high. T is the SCL tap count, so the first high phase is a full one.
- R8: After reset, `scl_o` is high and `sda_stb_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the SCL generator when high |
| div_we | input | 1 | Write strobe for the divider register |
| div_wdata | input | 8 | Divider value to write |
| div_rdata | output | 8 | Current divider register contents |
| scl_o | output | 1 | Generated serial clock |
| sda_stb_o | output | 1 | One-cycle SDA change strobe |

## Verification
A register write and an SCL falling edge can land on the same clock edge. At that edge, the active settings are reloaded from the register value from before the write. The bench forces this collision by timing a write to be captured exactly two SCL tap counts after an observed fall. It then expects the period that starts at that edge to keep the old timing, and only the next period to use the new timing. A second case places the write inside the high phase, and the very next period is expected to change.

// File: rtl/i2c_bitclk_pkg.sv
package i2c_bitclk_pkg;

  typedef struct packed {
    logic [1:0] mul_sel;
    logic [2:0] pre_sel;
    logic [2:0] tap_sel;
  } div_cfg_t;

  function automatic int mul_factor(logic [1:0] sel);
    case (sel)
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int pre_factor(logic [2:0] sel);
    return 2 * (int'(sel) + 1);
  endfunction

  function automatic int tick_len(div_cfg_t c);
    return mul_factor(c.mul_sel) * pre_factor(c.pre_sel);
  endfunction

  function automatic int scl_taps(logic [2:0] sel);
    case (sel)
      3'd0:    return 5;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 8;
      3'd4:    return 9;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 15;
    endcase
  endfunction

  function automatic int sda_taps(logic [2:0] sel);
    return int'(sel[2:1]) + 1;
  endfunction

endpackage

// File: rtl/i2c_bitclk_divreg.sv
module i2c_bitclk_divreg
  import i2c_bitclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       scl_fall,
  output logic [7:0] rdata,
  output div_cfg_t   act
);

  logic [7:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_q <= 8'h00;
    else if (we) reg_q <= wdata;
  end

  // Active settings reload only when idle or on an SCL fall (old register value).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                act <= '0;
    else if (!en || scl_fall)  act <= div_cfg_t'(reg_q);
  end

  assign rdata = reg_q;

endmodule

// File: rtl/i2c_bitclk_prescaler.sv
module i2c_bitclk_prescaler #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  output logic             tick
);

  logic [LEN_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == len - LEN_W'(1));
  assign tick = en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!en)   cnt_q <= '0;
    else if (last)  cnt_q <= '0;
    else            cnt_q <= cnt_q + LEN_W'(1);
  end

endmodule

// File: rtl/i2c_bitclk_phase.sv
module i2c_bitclk_phase #(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [TAP_W-1:0] scl_taps,
  input  logic [TAP_W-1:0] sda_taps,
  output logic             scl,
  output logic             sda_stb,
  output logic             scl_fall
);

  logic [TAP_W-1:0] half_q;
  logic             half_last;
  logic             sda_hit;

  assign half_last = (half_q == scl_taps - TAP_W'(1));
  assign sda_hit   = (half_q == sda_taps - TAP_W'(1));
  assign scl_fall  = tick && half_last && scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      scl     <= 1'b1;
      sda_stb <= 1'b0;
    end else if (!en) begin
      half_q  <= '0;
      scl     <= 1'b1;
      sda_stb <= 1'b0;
    end else begin
      sda_stb <= tick && !scl && sda_hit;
      if (tick) begin
        if (half_last) begin
          half_q <= '0;
          scl    <= ~scl;
        end else begin
          half_q <= half_q + TAP_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/i2c_bitclk_gen.sv
module i2c_bitclk_gen
  import i2c_bitclk_pkg::*;
#(
  parameter int MAX_TICK_LEN = 64,
  parameter int MAX_TAPS     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       div_we,
  input  logic [7:0] div_wdata,
  output logic [7:0] div_rdata,
  output logic       scl_o,
  output logic       sda_stb_o
);

  localparam int LEN_W = $clog2(MAX_TICK_LEN + 1);
  localparam int TAP_W = $clog2(MAX_TAPS + 1);

  div_cfg_t         act_cfg;
  logic [7:0]       act_bits_w;
  logic [LEN_W-1:0] len_w;
  logic [TAP_W-1:0] scl_taps_w;
  logic [TAP_W-1:0] sda_taps_w;
  logic             tick_w;
  logic             scl_fall_w;

  assign act_bits_w = act_cfg;
  assign len_w      = LEN_W'(tick_len(act_cfg));
  assign scl_taps_w = TAP_W'(scl_taps(act_cfg.tap_sel));
  assign sda_taps_w = TAP_W'(sda_taps(act_cfg.tap_sel));

  i2c_bitclk_divreg u_divreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .we       (div_we),
    .wdata    (div_wdata),
    .scl_fall (scl_fall_w),
    .rdata    (div_rdata),
    .act      (act_cfg)
  );

  i2c_bitclk_prescaler #(.LEN_W(LEN_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .len   (len_w),
    .tick  (tick_w)
  );

  i2c_bitclk_phase #(.TAP_W(TAP_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .tick     (tick_w),
    .scl_taps (scl_taps_w),
    .sda_taps (sda_taps_w),
    .scl      (scl_o),
    .sda_stb  (sda_stb_o),
    .scl_fall (scl_fall_w)
  );

endmodule

// File: rtl/i2c_bitclk_chk.sv
module i2c_bitclk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       div_we,
  input logic [7:0] div_wdata,
  input logic [7:0] div_rdata,
  input logic       scl,
  input logic       sda_stb,
  input logic       tick,
  input logic [7:0] act_cfg
);

  AST_RDATA_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> (div_rdata == $past(div_wdata)));                               // R1

  AST_SCL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (scl != $past(scl))) |-> $past(tick));                 // R2

  AST_STB_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |-> !scl);                                                         // R4

  AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |=> !sda_stb);                                                     // R4

  AST_CFG_HELD_TO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (act_cfg != $past(act_cfg))) |-> $fell(scl));          // R5

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !sda_stb));                                                // R6

endmodule

bind i2c_bitclk_gen i2c_bitclk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (enable),
  .div_we    (div_we),
  .div_wdata (div_wdata),
  .div_rdata (div_rdata),
  .scl       (scl_o),
  .sda_stb   (sda_stb_o),
  .tick      (tick_w),
  .act_cfg   (act_bits_w)
);

// File: tb/i2c_bitclk_gen_bench.sv
module i2c_bitclk_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       div_we = 1'b0;
  logic [7:0] div_wdata = 8'h00;
  logic [7:0] div_rdata;
  logic       scl_o;
  logic       sda_stb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {int low; int high; int off; string tag;} item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  i2c_bitclk_gen u_i2c_bitclk_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_we(div_we),
    .div_wdata(div_wdata), .div_rdata(div_rdata),
    .scl_o(scl_o), .sda_stb_o(sda_stb_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model written from the requirements.
  function automatic int m_tick(logic [7:0] v);
    int m;
    m = (v[7:6] == 2'd1) ? 2 : (v[7:6] == 2'd2) ? 4 : 1;
    return m * (2 + 2 * int'(v[5:3]));
  endfunction
  function automatic int m_scl(logic [7:0] v);
    int t[8] = '{5, 6, 7, 8, 9, 10, 12, 15};
    return t[v[2:0]];
  endfunction
  function automatic int m_sda(logic [7:0] v);
    return (int'(v[2:0]) >> 1) + 1;
  endfunction

  function automatic item_t mk(logic [7:0] v);
    item_t it;
    it.low  = m_scl(v) * m_tick(v);
    it.high = it.low;
    it.off  = m_sda(v) * m_tick(v);
    it.tag  = $sformatf("cfg=%02h", v);
    return it;
  endfunction

  // Monitor / scoreboard.
  int cyc = 0, t_fall = 0, t_rise = 0, n_stb = 0, off_seen = -1;
  bit prev_scl = 1'b1, active = 1'b0;
  item_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (active && sda_stb_o) begin
        n_stb++;
        off_seen = cyc - t_fall;
      end
      if (active && !prev_scl && scl_o) t_rise = cyc;
      if (prev_scl && !scl_o) begin
        if (active) begin
          chk(t_rise - t_fall == cur.low, {"R2 low ", cur.tag}, t_rise - t_fall, cur.low);
          chk(cyc - t_rise == cur.high, {"R3 high ", cur.tag}, cyc - t_rise, cur.high);
          chk(off_seen == cur.off, {"R4 offset ", cur.tag}, off_seen, cur.off);
          chk(n_stb == 1, {"R4 count ", cur.tag}, n_stb, 1);
          active = 1'b0;
        end
        if (exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          active = 1'b1;
          t_fall = cyc;
          n_stb = 0;
          off_seen = -1;
        end
      end
      prev_scl = scl_o;
    end
  end

  task automatic write_div(logic [7:0] v);
    @(negedge clk);
    div_we = 1'b1;
    div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
    chk(div_rdata == v, "R1 readback", div_rdata, v);
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() > 0 || active) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R6 scl high", scl_o, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!scl_o || sda_stb_o) bad++;
      end
      chk(bad == 0, "R6 idle", bad, 0);
    end
  endtask

  task automatic start_and_first_high(logic [7:0] v);
    int k = 0;
    @(negedge clk);
    enable = 1'b1;
    do begin
      @(negedge clk);
      k++;
    end while (scl_o);
    chk(k == m_scl(v) * m_tick(v), "R7 first high", k, m_scl(v) * m_tick(v));
  endtask

  task automatic run_cfg(logic [7:0] v, int nper);
    write_div(v);
    for (int i = 0; i < nper; i++) exp_q.push_back(mk(v));
    start_and_first_high(v);
    drain_and_stop();
  endtask

  // R5: write captured at edge skip cycles after the first observed fall.
  task automatic run_change(logic [7:0] a, logic [7:0] b, bit collide);
    int span;
    write_div(a);
    exp_q.push_back(mk(a));
    if (collide) exp_q.push_back(mk(a));
    exp_q.push_back(mk(b));
    exp_q.push_back(mk(b));
    span = m_scl(a) * m_tick(a);
    start_and_first_high(a);
    repeat (collide ? 2 * span - 1 : span + 2) @(negedge clk);
    div_we = 1'b1;
    div_wdata = b;
    @(negedge clk);
    div_we = 1'b0;
    chk(div_rdata == b, "R5 R1 write while running", div_rdata, b);
    drain_and_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R8 reset scl", scl_o, 1);
    chk(sda_stb_o == 1'b0, "R8 reset strobe", sda_stb_o, 0);
    chk(div_rdata == 8'h00, "R1 reset value", div_rdata, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) run_cfg(8'(c), 3);
    run_cfg(8'b01_010_011, 2);
    run_cfg(8'b11_001_100, 2);
    run_cfg(8'b10_111_111, 2);
    run_cfg(8'b00_111_110, 2);
    run_change(8'b00_001_010, 8'b01_000_101, 1'b0);
    run_change(8'b00_001_010, 8'b01_000_101, 1'b1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule